// File: doc/BRIEF.md
# Memory Boundary-Scan Test Port

This block is the serial test port of a memory device. A sixteen-state controller advances on each rising edge of the test clock, steered by the mode-select input. A three-bit instruction register selects one of three data registers for the serial path from the test data input to the test data output. These are a one-bit bypass cell, a 32-bit identification word and a boundary register whose length is a parameter. Both the instruction register and the selected data register shift least-significant bit first.

The instruction set departs from the usual boundary-scan standard. The external-test instruction does not drive stored values onto the pins. Instead it samples the I/O ring and floats the data pins. The sample instruction has no preload-to-pins path. A third capture instruction also floats the data pins. Three codes are reserved and act as bypass.

The block tells the I/O ring when to present its state for capture. It also holds a high-impedance force on the data pins while a floating instruction is active. The power-up reset is synchronous and active high. It places the controller in its reset state and loads the identification instruction.

Top module: `sram_tap`

## Requirements
- R1: Every controller transition is taken on the rising edge of `tck` from `tms`, following the standard sixteen-state scan diagram. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state.
- R2: While `rst` is high, or on any falling edge with the controller in Test-Logic-Reset, the active instruction becomes the identification code 001. After that edge `dq_hiz` is low.
- R3: Capture-IR loads the instruction shift register with 001. In Shift-IR, `tdi` enters at bit 2 and bit 0 leaves on `tdo`, so a code is sent bit 0 first. The shifted code becomes active on the falling edge of `tck` in Update-IR.
- R4: Code 001 selects the 32-bit identification register. This register loads `ID_VALUE` in Capture-DR and shifts out bit 0 first.
- R5: Codes 000 (external test), 100 (sample) and 010 (sample with float) select the boundary register. `ring_capture` is high during Capture-DR under these codes. On the rising edge that leaves Capture-DR, `pins_in` is loaded. The register shifts out bit 0 first, and `tdi` enters at its top bit.
- R6: Code 111 and the reserved codes 011, 101 and 110 select the one-bit bypass cell. This cell captures 0 and delays `tdi` by one shift.
- R7: `dq_hiz` is high exactly while the active instruction is 000 or 010. It is low under 001, 100, 111, 011, 101 and 110.
- R8: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high only in Shift-IR or Shift-DR, and `tdo` is 0 whenever `tdo_en` is low.
- R9: Data-register scans, including Pause-DR and Update-DR, and instruction shifting before Update-IR leave the active instruction and `dq_hiz` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| pins_in | input | BSR_LEN | I/O ring state offered for capture |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_en | output | 1 | Output enable for `tdo` |
| dq_hiz | output | 1 | Forces the data pin drivers to high impedance |
| ring_capture | output | 1 | Asks the I/O ring to present its state for capture |

## Verification
The assertions assume that `tms` and `tdi` are stable around each rising edge of `tck`. They also assume that `rst` is held for at least one full clock at start-up, so both the rising-edge and falling-edge registers see it. The bench changes its inputs one nanosecond after each falling edge and samples outputs in the same window. It asserts reset for several cycles before any scan. Every instruction scan starts from Run-Test/Idle and uses only legal `tms` sequences. The five-ones reset walk is also started from inside Shift-DR, so the assertion that counts `tms` highs meets a mid-scan state.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;
    localparam logic [IR_W-1:0] IR_CAPTURE_PATTERN = 3'b001;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST  = 3'b000,
        OP_IDCODE  = 3'b001,
        OP_SAMPLEZ = 3'b010,
        OP_RSV3    = 3'b011,
        OP_SAMPLE  = 3'b100,
        OP_RSV5    = 3'b101,
        OP_RSV6    = 3'b110,
        OP_BYPASS  = 3'b111
    } opcode_t;

    typedef enum logic [1:0] {
        SEL_BYP,
        SEL_ID,
        SEL_BSR
    } dr_sel_t;

    typedef struct packed {
        dr_sel_t sel;
        logic    hiz;
    } op_ctl_t;

    function automatic tap_state_t tap_next(input tap_state_t s, input logic m);
        tap_state_t n;
        unique case (s)
            TS_RESET:  n = m ? TS_RESET  : TS_IDLE;
            TS_IDLE:   n = m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: n = m ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  n = m ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: n = m ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: n = m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: n = m ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: n = m ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  n = m ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: n = m ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: n = m ? TS_SEL_DR : TS_IDLE;
            default:   n = TS_RESET;
        endcase
        return n;
    endfunction

    function automatic op_ctl_t op_decode(input opcode_t op);
        op_ctl_t c;
        unique case (op)
            OP_EXTEST:  c = '{sel: SEL_BSR, hiz: 1'b1};
            OP_SAMPLEZ: c = '{sel: SEL_BSR, hiz: 1'b1};
            OP_SAMPLE:  c = '{sel: SEL_BSR, hiz: 1'b0};
            OP_IDCODE:  c = '{sel: SEL_ID,  hiz: 1'b0};
            default:    c = '{sel: SEL_BYP, hiz: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_t state
);

    always_ff @(posedge tck) begin
        if (rst) begin
            state <= TS_RESET;
        end else begin
            state <= tap_next(state, tms);
        end
    end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tdi,
    input  tap_state_t state,
    output opcode_t    active,
    output logic       sh_lsb
);

    logic [IR_W-1:0] sh_q;

    // Shift stage: rising edge
    always_ff @(posedge tck) begin
        if (rst) begin
            sh_q <= IR_CAPTURE_PATTERN;
        end else if (state == TS_CAP_IR) begin
            sh_q <= IR_CAPTURE_PATTERN;
        end else if (state == TS_SH_IR) begin
            sh_q <= {tdi, sh_q[IR_W-1:1]};
        end
    end

    // Active stage: falling edge
    always_ff @(negedge tck) begin
        if (rst || state == TS_RESET) begin
            active <= OP_IDCODE;
        end else if (state == TS_UPD_IR) begin
            active <= opcode_t'(sh_q);
        end
    end

    assign sh_lsb = sh_q[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0A5C_3E6B,
    parameter int              BSR_LEN  = 8
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tdi,
    input  tap_state_t         state,
    input  dr_sel_t            sel,
    input  logic [BSR_LEN-1:0] pins,
    output logic               dr_lsb
);

    logic               byp_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bsr_q;

    logic cap_en, sh_en;
    assign cap_en = (state == TS_CAP_DR);
    assign sh_en  = (state == TS_SH_DR);

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
        end else if (cap_en) begin
            byp_q <= 1'b0;
        end else if (sh_en && sel == SEL_BYP) begin
            byp_q <= tdi;
        end
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            id_q <= ID_VALUE;
        end else if (cap_en && sel == SEL_ID) begin
            id_q <= ID_VALUE;
        end else if (sh_en && sel == SEL_ID) begin
            id_q <= {tdi, id_q[ID_W-1:1]};
        end
    end

    generate
        if (BSR_LEN > 1) begin : g_bsr_chain
            always_ff @(posedge tck) begin
                if (rst) begin
                    bsr_q <= '0;
                end else if (cap_en && sel == SEL_BSR) begin
                    bsr_q <= pins;
                end else if (sh_en && sel == SEL_BSR) begin
                    bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
                end
            end
        end else begin : g_bsr_cell
            always_ff @(posedge tck) begin
                if (rst) begin
                    bsr_q <= '0;
                end else if (cap_en && sel == SEL_BSR) begin
                    bsr_q <= pins;
                end else if (sh_en && sel == SEL_BSR) begin
                    bsr_q <= tdi;
                end
            end
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_ID:  dr_lsb = id_q[0];
            SEL_BSR: dr_lsb = bsr_q[0];
            default: dr_lsb = byp_q;
        endcase
    end

endmodule

// File: rtl/sram_tap.sv
module sram_tap
    import tap_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0A5C_3E6B,
    parameter int              BSR_LEN  = 8
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pins_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic               dq_hiz,
    output logic               ring_capture
);

    tap_state_t state_q;
    opcode_t    ir_active;
    op_ctl_t    ctl;
    logic       ir_lsb;
    logic       dr_lsb;
    logic       in_shift;

    tap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (state_q)
    );

    tap_ir u_ir (
        .tck    (tck),
        .rst    (rst),
        .tdi    (tdi),
        .state  (state_q),
        .active (ir_active),
        .sh_lsb (ir_lsb)
    );

    assign ctl = op_decode(ir_active);

    tap_dr #(
        .ID_VALUE (ID_VALUE),
        .BSR_LEN  (BSR_LEN)
    ) u_dr (
        .tck    (tck),
        .rst    (rst),
        .tdi    (tdi),
        .state  (state_q),
        .sel    (ctl.sel),
        .pins   (pins_in),
        .dr_lsb (dr_lsb)
    );

    assign in_shift = (state_q == TS_SH_IR) || (state_q == TS_SH_DR);

    // Output retimed on the falling edge
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= in_shift;
            if (!in_shift) begin
                tdo <= 1'b0;
            end else if (state_q == TS_SH_IR) begin
                tdo <= ir_lsb;
            end else begin
                tdo <= dr_lsb;
            end
        end
    end

    assign dq_hiz       = ctl.hiz;
    assign ring_capture = (state_q == TS_CAP_DR) && (ctl.sel == SEL_BSR);

endmodule

// File: rtl/tap_checker.sv
module tap_checker
    import tap_pkg::*;
(
    input logic       tck,
    input logic       rst,
    input logic       tms,
    input logic       tdo,
    input logic       tdo_en,
    input logic       dq_hiz,
    input logic       ring_capture,
    input tap_state_t state,
    input opcode_t    active_ir
);

    logic       pos_ok = 1'b0;
    logic       neg_ok = 1'b0;
    logic [2:0] ones_cnt;

    always_ff @(posedge tck) begin
        pos_ok <= !rst;
        if (rst) begin
            ones_cnt <= 3'd0;
        end else if (tms) begin
            ones_cnt <= (ones_cnt == 3'd5) ? 3'd5 : ones_cnt + 3'd1;
        end else begin
            ones_cnt <= 3'd0;
        end
    end

    always_ff @(negedge tck) begin
        neg_ok <= !rst;
    end

    // R1: five high mode-select samples land in reset
    assert_five_ones_R1: assert property (@(posedge tck) disable iff (rst || !pos_ok)
        (ones_cnt == 3'd5) |-> (state == TS_RESET));

    // R2: a full cycle in reset leaves identification active and pins released
    assert_reset_release_R2: assert property (@(posedge tck) disable iff (rst || !pos_ok || !neg_ok)
        (state == TS_RESET && $past(state) == TS_RESET) |-> (!dq_hiz && active_ir == OP_IDCODE));

    // R9: active instruction moves only after Update-IR or reset
    assert_ir_hold_R9: assert property (@(negedge tck) disable iff (rst || !neg_ok)
        !($past(state) == TS_RESET || $past(state) == TS_UPD_IR) |-> $stable(active_ir));

    // R8: output enable tracks the shift states
    assert_enable_track_R8: assert property (@(posedge tck) disable iff (rst || !neg_ok)
        tdo_en == (state == TS_SH_IR || state == TS_SH_DR));

    // R8: disabled output is quiet
    assert_quiet_out_R8: assert property (@(posedge tck) disable iff (rst || !neg_ok)
        !tdo_en |-> !tdo);

    // R5: capture strobe is followed by shift or exit
    assert_capture_follow_R5: assert property (@(posedge tck) disable iff (rst || !pos_ok)
        ring_capture |=> (state == TS_SH_DR || state == TS_EX1_DR));

    // R7: float force only rises after an instruction update
    assert_hiz_rise_R7: assert property (@(posedge tck) disable iff (rst || !pos_ok || !neg_ok)
        $rose(dq_hiz) |-> (state == TS_UPD_IR));

endmodule

bind sram_tap tap_checker u_chk (
    .tck          (tck),
    .rst          (rst),
    .tms          (tms),
    .tdo          (tdo),
    .tdo_en       (tdo_en),
    .dq_hiz       (dq_hiz),
    .ring_capture (ring_capture),
    .state        (state_q),
    .active_ir    (ir_active)
);

// File: tb/sim_sram_tap.sv
`timescale 1ns/1ps
module sim_sram_tap;

    localparam logic [31:0] IDV   = 32'h0A5C_3E6B;
    localparam int          BSR_N = 8;

    // behavioural state numbering for the bench model
    localparam int S_RST = 0,  S_IDL = 1,  S_SDR = 2,  S_CDR = 3,  S_HDR = 4,
                   S_E1D = 5,  S_PDR = 6,  S_E2D = 7,  S_UDR = 8,  S_SIR = 9,
                   S_CIR = 10, S_HIR = 11, S_E1I = 12, S_PIR = 13, S_E2I = 14,
                   S_UIR = 15;

    logic             tck = 1'b0;
    logic             rst = 1'b1;
    logic             tms = 1'b1;
    logic             tdi = 1'b0;
    logic [BSR_N-1:0] pins = '0;
    logic             tdo, tdo_en, dq_hiz, ring_capture;

    int n_cmp = 0;
    int n_bad = 0;

    // model state
    int         st;
    logic [2:0] m_irsh;
    logic [2:0] m_ir;
    bit         m_byp;
    bit         m_id[$];
    bit         m_bsr[$];
    logic       m_tdo, m_en;

    always #2 tck = ~tck;

    sram_tap #(.ID_VALUE(IDV), .BSR_LEN(BSR_N)) u0 (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .pins_in(pins),
        .tdo(tdo), .tdo_en(tdo_en), .dq_hiz(dq_hiz), .ring_capture(ring_capture)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int nxt(input int s, input bit m);
        case (s)
            S_RST: return m ? S_RST : S_IDL;
            S_IDL: return m ? S_SDR : S_IDL;
            S_SDR: return m ? S_SIR : S_CDR;
            S_CDR: return m ? S_E1D : S_HDR;
            S_HDR: return m ? S_E1D : S_HDR;
            S_E1D: return m ? S_UDR : S_PDR;
            S_PDR: return m ? S_E2D : S_PDR;
            S_E2D: return m ? S_UDR : S_HDR;
            S_UDR: return m ? S_SDR : S_IDL;
            S_SIR: return m ? S_RST : S_CIR;
            S_CIR: return m ? S_E1I : S_HIR;
            S_HIR: return m ? S_E1I : S_HIR;
            S_E1I: return m ? S_UIR : S_PIR;
            S_PIR: return m ? S_E2I : S_PIR;
            S_E2I: return m ? S_UIR : S_HIR;
            default: return m ? S_SDR : S_IDL;
        endcase
    endfunction

    // 0 bypass, 1 identification, 2 boundary
    function automatic int msel(input logic [2:0] c);
        if (c == 3'b001) return 1;
        if (c == 3'b000 || c == 3'b010 || c == 3'b100) return 2;
        return 0;
    endfunction

    task automatic model_pos();
        if (rst) begin
            st = S_RST;
            m_irsh = 3'b001;
            m_byp = 1'b0;
            m_id.delete();
            for (int i = 0; i < 32; i++) m_id.push_back(IDV[i]);
            m_bsr.delete();
            for (int i = 0; i < BSR_N; i++) m_bsr.push_back(1'b0);
        end else begin
            if (st == S_CIR) m_irsh = 3'b001;
            else if (st == S_HIR) m_irsh = {tdi, m_irsh[2:1]};
            if (st == S_CDR) begin
                m_byp = 1'b0;
                if (msel(m_ir) == 1) begin
                    m_id.delete();
                    for (int i = 0; i < 32; i++) m_id.push_back(IDV[i]);
                end else if (msel(m_ir) == 2) begin
                    m_bsr.delete();
                    for (int i = 0; i < BSR_N; i++) m_bsr.push_back(pins[i]);
                end
            end else if (st == S_HDR) begin
                if (msel(m_ir) == 0) m_byp = tdi;
                else if (msel(m_ir) == 1) begin void'(m_id.pop_front()); m_id.push_back(tdi); end
                else begin void'(m_bsr.pop_front()); m_bsr.push_back(tdi); end
            end
            st = nxt(st, tms);
        end
    endtask

    task automatic model_neg();
        if (rst) begin
            m_tdo = 1'b0; m_en = 1'b0; m_ir = 3'b001;
        end else begin
            m_en = (st == S_HIR || st == S_HDR);
            if (!m_en) m_tdo = 1'b0;
            else if (st == S_HIR) m_tdo = m_irsh[0];
            else if (msel(m_ir) == 0) m_tdo = m_byp;
            else if (msel(m_ir) == 1) m_tdo = m_id[0];
            else m_tdo = m_bsr[0];
            if (st == S_RST) m_ir = 3'b001;
            else if (st == S_UIR) m_ir = m_irsh;
        end
    endtask

    task automatic compare_all();
        string tg;
        if (st == S_HIR) tg = "R3 tdo(ir)";
        else if (msel(m_ir) == 1) tg = "R4 tdo(id)";
        else if (msel(m_ir) == 2) tg = "R5 tdo(bsr)";
        else tg = "R6 tdo(bypass)";
        chk(tg, {63'd0, tdo}, {63'd0, m_tdo});
        chk("R8 tdo_en", {63'd0, tdo_en}, {63'd0, m_en});
        chk("R7 dq_hiz", {63'd0, dq_hiz}, {63'd0, (m_ir == 3'b000 || m_ir == 3'b010)});
        chk("R5 ring_capture", {63'd0, ring_capture}, {63'd0, (st == S_CDR && msel(m_ir) == 2)});
    endtask

    // one clock: drive, rising edge model, falling edge model, compare
    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        model_pos();
        @(negedge tck);
        model_neg();
        #1;
        compare_all();
    endtask

    task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < 3; i++) begin
            cap[i] = tdo;
            tick(i == 2, code[i]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, input bit pause,
                           output logic [63:0] dout);
        dout = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            if (pause && i == 2) begin
                tick(1, din[i]); tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
            end else begin
                tick(i == n - 1, din[i]);
            end
        end
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [2:0]  cap;
        logic [63:0] dout;
        logic [2:0]  rsv[3];
        rsv[0] = 3'b011; rsv[1] = 3'b101; rsv[2] = 3'b110;

        // R2: power-up reset
        rst = 1'b1;
        repeat (3) tick(1, 0);
        rst = 1'b0;
        chk("R2 reset dq_hiz", {63'd0, dq_hiz}, 64'd0);
        chk("R2 reset tdo_en", {63'd0, tdo_en}, 64'd0);
        tick(0, 0);

        // R4: identification word after reset
        scan_dr(32, 64'h0, 1'b0, dout);
        chk("R4 id word", dout[31:0], IDV);

        // R3, R6: bypass and captured pattern
        load_ir(3'b111, cap);
        chk("R3 ir capture", cap, 3'b001);
        scan_dr(8, 64'hA5, 1'b0, dout);
        chk("R6 bypass delay", dout[7:0], {8'hA5, 1'b0} & 8'hFF);

        // R6: reserved codes behave as bypass
        foreach (rsv[k]) begin
            load_ir(rsv[k], cap);
            chk("R7 reserved no float", {63'd0, dq_hiz}, 64'd0);
            scan_dr(6, 64'h2D, 1'b0, dout);
            chk("R6 reserved bypass", dout[5:0], {6'h2D, 1'b0} & 6'h3F);
        end

        // R5, R7: sample with pause
        pins = 8'h3C;
        load_ir(3'b100, cap);
        chk("R7 sample no float", {63'd0, dq_hiz}, 64'd0);
        scan_dr(BSR_N, 64'h5A, 1'b1, dout);
        chk("R5 sample capture", dout[BSR_N-1:0], 8'h3C);
        pins = 8'hC3;
        scan_dr(BSR_N, 64'h00, 1'b0, dout);
        chk("R5 sample recapture", dout[BSR_N-1:0], 8'hC3);

        // R5, R7, R9: external test floats and holds through data scans
        pins = 8'h96;
        load_ir(3'b000, cap);
        chk("R7 extest float", {63'd0, dq_hiz}, 64'd1);
        scan_dr(BSR_N, 64'hFF, 1'b1, dout);
        chk("R5 extest capture", dout[BSR_N-1:0], 8'h96);
        chk("R9 float held after update-dr", {63'd0, dq_hiz}, 64'd1);

        // R9: instruction shift without update keeps the float
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        tick(0, 1); tick(0, 1);
        chk("R9 float held in shift-ir", {63'd0, dq_hiz}, 64'd1);

        // R1, R2: five ones from mid-scan
        repeat (5) tick(1, 0);
        chk("R1 reset walk", {63'd0, dq_hiz}, 64'd0);
        tick(0, 0);
        load_ir(3'b010, cap);
        tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);
        repeat (5) tick(1, 0);
        chk("R2 reset from shift-dr", {63'd0, dq_hiz}, 64'd0);
        tick(0, 0);

        // R5, R7: sample with float
        pins = 8'h71;
        load_ir(3'b010, cap);
        chk("R7 samplez float", {63'd0, dq_hiz}, 64'd1);
        scan_dr(BSR_N, 64'h0F, 1'b0, dout);
        chk("R5 samplez capture", dout[BSR_N-1:0], 8'h71);

        // R4: explicit identification code
        load_ir(3'b001, cap);
        chk("R7 idcode no float", {63'd0, dq_hiz}, 64'd0);
        scan_dr(32, 64'h1234_5678, 1'b1, dout);
        chk("R4 id word again", dout[31:0], IDV);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule